// File: doc/BRIEF.md
# Bus Master Start-Up Command Sequencer

After reset, this block acts as the only master on a simple synchronous register bus that uses cyc/stb/we/ack signalling in the Wishbone style. It runs a fixed, ordered script of single read and write transactions that set up a 16550-style serial port register file. When the script is finished it halts, and it leaves the bus idle from then on.

The script is a constant array of commands in a package. Each entry gives an operation (idle, plain read, write, or status read), an 8-bit register address and an 8-bit value. Step numbers are derived from the array index, so adding a command needs no renumbering.

Each command step is followed by one idle step in which cyc, stb and we are low. A command step holds the bus until the slave answers with ack. A status read captures the transmitter-empty bit from the read data. A `done` flag marks the end of the script.

Top module: `initseq_top`

## Requirements
- R1: After reset is released, the commands appear on the bus in this order:
  1. status read of address 5;
  2. read of address 0;
  3. read of address 0;
  4. write of 0x60 to address 3;
  5. write of 0x01 to address 0;
  6. write of 0x55 to address 0.

  The first command is driven on the first clock edge after reset is released.
- R2: During a read or status-read step, `wbAdr` holds the target address, `wbCyc` and `wbStb` are 1, and `wbWe` is 0.
- R3: During a write step, `wbAdr` holds the target address, `wbWdat` holds the value, and `wbCyc`, `wbStb` and `wbWe` are all 1.
- R4: On the clock edge that samples `wbAck` high during a command step, the block enters an idle step. The idle step lasts exactly one cycle, with `wbCyc`, `wbStb` and `wbWe` all 0 and `wbAdr` unchanged. The next command follows on the next edge.
- R5: A command step keeps its address, data and strobes unchanged for as many cycles as `wbAck` stays low.
- R6: An asynchronous high `rst` drives the following values:
  - `wbCyc`, `wbStb`, `wbWe`, `wbAdr`, `wbWdat` and `done` to 0;
  - `txEmpty` to 1.
- R7: Once the last command has been acknowledged, `done` is 1 and stays 1. The bus then stays idle, and any further `wbAck` has no effect.
- R8: On the edge where `wbAck` is high during the status-read step, `txEmpty` takes bit 6 of `wbRdat`. The other read-data bits have no effect. Plain reads never change `txEmpty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| wbAck | input | 1 | Slave acknowledge |
| wbRdat | input | 8 | Slave read data |
| wbCyc | output | 1 | Bus cycle active |
| wbStb | output | 1 | Transfer strobe |
| wbWe | output | 1 | Write enable |
| wbAdr | output | 8 | Register address |
| wbWdat | output | 8 | Write data |
| txEmpty | output | 1 | Captured transmitter-empty flag |
| done | output | 1 | Script finished |

## Verification
The hardest situation to reach is a command held for several cycles waiting on a slow slave. Then, in the same run, `txEmpty` must take each value and ignore the other read bits. The bench drives a slave model with an acknowledge delay swept from zero to three cycles. It crosses that sweep with both values of the status bit, and the read data carries the opposite value in every other bit. Each run also pulses ack after the script ends, to show that the halted bus stays idle.

// File: rtl/initseq_pkg.sv
package initseq_pkg;
  localparam int ADR_W      = 8;
  localparam int DAT_W      = 8;
  localparam int STATUS_BIT = 6;

  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_WRITE, OP_STATUS} opE;

  typedef struct packed {
    opE               op;
    logic [ADR_W-1:0] adr;
    logic [DAT_W-1:0] val;
  } cmdT;

  typedef struct packed {
    logic load;     // next step is a command: drive it
    logic drop;     // next step is idle: release strobes
    logic capture;  // status read acknowledged this cycle
  } strobeT;

  localparam logic [ADR_W-1:0] REG_TXH = 8'd0;
  localparam logic [ADR_W-1:0] REG_DIV = 8'd0;
  localparam logic [ADR_W-1:0] REG_LCR = 8'd3;
  localparam logic [ADR_W-1:0] REG_LSR = 8'd5;

  // Script length; step numbering is derived from it everywhere.
  localparam int NUM_CMD = 6;
  typedef cmdT cmdListT [NUM_CMD];

  localparam cmdListT CMD_LIST = '{
    '{op: OP_STATUS, adr: REG_LSR, val: 8'h00},
    '{op: OP_READ,   adr: REG_DIV, val: 8'h00},
    '{op: OP_READ,   adr: REG_DIV, val: 8'h00},
    '{op: OP_WRITE,  adr: REG_LCR, val: 8'h60},
    '{op: OP_WRITE,  adr: REG_DIV, val: 8'h01},
    '{op: OP_WRITE,  adr: REG_TXH, val: 8'h55}
  };

  function automatic cmdT cmdAt(int unsigned idx);
    cmdT r;
    r = '0;
    if (idx < NUM_CMD) r = CMD_LIST[idx];
    return r;
  endfunction
endpackage

// File: rtl/initseq_ctrl.sv
module initseq_ctrl
  import initseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wbAck,
  output strobeT strb,
  output cmdT    nextCmd,
  output logic   done
);
  localparam int LAST   = 2 * NUM_CMD;
  localparam int STEP_W = $clog2(LAST + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(LAST);

  // Step 0 idle, step 2k+1 runs command k, step 2k+2 idle.
  logic [STEP_W-1:0] step;
  cmdT  curCmd;
  logic isCmd;
  logic waitAck;
  logic advance;

  always_comb begin
    isCmd   = step[0];
    curCmd  = isCmd ? cmdAt(int'(step >> 1)) : '0;
    waitAck = isCmd && (curCmd.op != OP_IDLE);
    advance = (step != LAST_STEP) && (!waitAck || wbAck);
    nextCmd = cmdAt(int'(step >> 1));
    strb.load    = advance && !isCmd;
    strb.drop    = advance && isCmd;
    strb.capture = isCmd && wbAck && (curCmd.op == OP_STATUS);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          step <= '0;
    else if (advance) step <= step + 1'b1;
  end

  assign done = (step == LAST_STEP);
endmodule

// File: rtl/initseq_dp.sv
module initseq_dp
  import initseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  strobeT           strb,
  input  cmdT              nextCmd,
  input  logic [DAT_W-1:0] wbRdat,
  output logic             wbCyc,
  output logic             wbStb,
  output logic             wbWe,
  output logic [ADR_W-1:0] wbAdr,
  output logic [DAT_W-1:0] wbWdat,
  output logic             txEmpty
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wbCyc  <= 1'b0;
      wbStb  <= 1'b0;
      wbWe   <= 1'b0;
      wbAdr  <= '0;
      wbWdat <= '0;
    end else if (strb.load) begin
      wbAdr <= nextCmd.adr;
      wbCyc <= (nextCmd.op != OP_IDLE);
      wbStb <= (nextCmd.op != OP_IDLE);
      wbWe  <= (nextCmd.op == OP_WRITE);
      if (nextCmd.op == OP_WRITE) wbWdat <= nextCmd.val;
    end else if (strb.drop) begin
      wbCyc <= 1'b0;
      wbStb <= 1'b0;
      wbWe  <= 1'b0;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)               txEmpty <= 1'b1;
    else if (strb.capture) txEmpty <= wbRdat[STATUS_BIT];
  end
endmodule

// File: rtl/initseq_top.sv
module initseq_top
  import initseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wbAck,
  input  logic [DAT_W-1:0] wbRdat,
  output logic             wbCyc,
  output logic             wbStb,
  output logic             wbWe,
  output logic [ADR_W-1:0] wbAdr,
  output logic [DAT_W-1:0] wbWdat,
  output logic             txEmpty,
  output logic             done
);
  strobeT strb;
  cmdT    nextCmd;

  initseq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wbAck(wbAck),
    .strb(strb), .nextCmd(nextCmd), .done(done)
  );

  initseq_dp u_dp (
    .clk(clk), .rst(rst), .strb(strb), .nextCmd(nextCmd), .wbRdat(wbRdat),
    .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe), .wbAdr(wbAdr),
    .wbWdat(wbWdat), .txEmpty(txEmpty)
  );
endmodule

// File: rtl/initseq_chk.sv
module initseq_chk (
  input logic       clk,
  input logic       rst,
  input logic       wbAck,
  input logic       wbCyc,
  input logic       wbStb,
  input logic       wbWe,
  input logic [7:0] wbAdr,
  input logic       txEmpty,
  input logic       done
);
  p_idle_after_ack_r4: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbAck) |=> (!wbCyc && !wbStb && !wbWe && $stable(wbAdr)));

  p_hold_until_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && !wbAck) |=> (wbCyc && wbStb && $stable(wbAdr) && $stable(wbWe)));

  p_we_inside_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    wbWe |-> (wbCyc && wbStb));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !wbCyc && !wbStb));

  p_status_source_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(txEmpty) |-> $past(wbCyc && wbAck && !wbWe && wbAdr == 8'd5));
endmodule

bind initseq_top initseq_chk u_chk (.*);

// File: tb/initseq_top_tb.sv
module initseq_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wbAck = 1'b0;
  logic [7:0] wbRdat = 8'h00;
  logic       wbCyc, wbStb, wbWe, txEmpty, done;
  logic [7:0] wbAdr, wbWdat;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  initseq_top u_dut (
    .clk(clk), .rst(rst), .wbAck(wbAck), .wbRdat(wbRdat),
    .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe), .wbAdr(wbAdr),
    .wbWdat(wbWdat), .txEmpty(txEmpty), .done(done)
  );

  // Expected script: kind 0 status read, 1 read, 2 write
  int         expKind [6] = '{0, 1, 1, 2, 2, 2};
  logic [7:0] expAdr  [6] = '{8'd5, 8'd0, 8'd0, 8'd3, 8'd0, 8'd0};
  logic [7:0] expVal  [6] = '{8'h00, 8'h00, 8'h00, 8'h60, 8'h01, 8'h55};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkCmd(input int k, input string req);
    chk({req, " cyc"}, wbCyc, 1);
    chk({req, " stb"}, wbStb, 1);
    chk({req, " adr"}, wbAdr, expAdr[k]);
    chk({req, " we"}, wbWe, expKind[k] == 2);
    if (expKind[k] == 2) chk({req, " wdat"}, wbWdat, expVal[k]);
  endtask

  task automatic runOnce(input int delay, input logic lsrBit);
    rst = 1'b1; wbAck = 1'b0;
    repeat (2) @(negedge clk);
    // R6 reset values
    chk("R6 reset cyc", wbCyc, 0);
    chk("R6 reset stb", wbStb, 0);
    chk("R6 reset we", wbWe, 0);
    chk("R6 reset adr", wbAdr, 0);
    chk("R6 reset wdat", wbWdat, 0);
    chk("R6 reset txEmpty", txEmpty, 1);
    chk("R6 reset done", done, 0);
    rst = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      // R1 order, R2 read fields, R3 write fields
      checkCmd(k, (expKind[k] == 2) ? "R3 R1 write" : "R2 R1 read");
      if (k == 0) chk("R8 txEmpty before ack", txEmpty, 1);
      chk("R7 done low mid-script", done, 0);
      for (int d = 0; d < delay; d++) begin
        @(negedge clk);
        checkCmd(k, "R5 held without ack");
      end
      wbAck  = 1'b1;
      wbRdat = lsrBit ? 8'h40 : 8'hBF;
      @(negedge clk);
      wbAck  = 1'b0;
      wbRdat = 8'h00;
      // R4 one idle step with address held
      chk("R4 idle cyc", wbCyc, 0);
      chk("R4 idle stb", wbStb, 0);
      chk("R4 idle we", wbWe, 0);
      chk("R4 idle adr held", wbAdr, expAdr[k]);
      // R8 status capture, plain reads leave it
      chk("R8 txEmpty", txEmpty, lsrBit);
    end
    chk("R7 done set", done, 1);
    for (int i = 0; i < 4; i++) begin
      wbAck  = (i % 2 == 0);
      wbRdat = lsrBit ? 8'hBF : 8'h40;
      @(negedge clk);
      chk("R7 halted cyc", wbCyc, 0);
      chk("R7 halted stb", wbStb, 0);
      chk("R7 done sticky", done, 1);
      chk("R8 txEmpty kept after halt", txEmpty, lsrBit);
    end
    wbAck = 1'b0;
  endtask

  initial begin
    for (int d = 0; d < 4; d++)
      for (int b = 0; b < 2; b++)
        runOnce(d, b[0]);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule